// File: doc/BRIEF.md
# Glitch-Free Dual-Channel CPU Clock Switch

This block builds the CPU clock from free-running inputs: a crystal reference, two fixed clocks at half and a third of a common rate, and a PLL clock. It contains two identical channels. Each channel picks one of the three fixed sources, passes that clock through an integer divider, and then forwards either the raw source or the divided clock. A dynamic selector decides which channel feeds the core. A final selector then chooses between that dynamic path and the PLL clock. Every selector changes over without glitches. The old clock is gated off at its own falling edge after a two-flop synchronised handshake. Only after that is the new clock gated on at its falling edge.

Software reprograms one channel while the other drives the core, and channel 1 acts as the fixed-rate parking clock. A new divide ratio is armed and committed through an enable bit, and the ratio changes only when that bit falls. The block also holds the multiplier setting that goes to the PLL, and it rejects values outside the legal window. Two status outputs report which channel and which top-level source are driving the core. Each status output changes only after the handshake for that switch has completed.

Top module: `cpuclk_switch`

## Requirements
- R1: After the active-low asynchronous reset, channel 0 uses the crystal undivided, the dynamic path drives the output (so cpu_clk runs at the crystal period), both status outputs read 0, and pll_mult reads 128.
- R2: In a channel word (address 0 for channel 0, address 1 for channel 1), bits [1:0] pick the channel's source: 0 selects the crystal, 1 selects the half-rate fixed clock, 2 selects the third-rate fixed clock, and 3 is treated as the crystal.
- R3: Channel word bit 4 set to 1 forwards the divided clock; set to 0 it forwards the raw source. The divide ratio is the committed 6-bit field plus 2, so the output period is (field+2) times the source period.
- R4: The divide field in channel word bits [13:8] is committed only by a write that has bit 26 at 0 while the channel's stored bit 26 is 1. The new ratio applies from the next output period boundary.
- R5: A channel word write with no 1-to-0 change of bit 26 leaves the channel's divide ratio unchanged, whatever its bits [13:8] hold.
- R6: At address 2, bit 0 selects channel 0 (value 0) or channel 1 (value 1) for the dynamic path. Bit 4 set to 1 selects the PLL clock at the top level; set to 0 it selects the dynamic path.
- R7: While channel 1 is selected by address 2 bit 0, or is still reported active, writes to channel 1's source and post-select fields (bits [1:0] and bit 4) are ignored.
- R8: active_chan and active_pll keep their old value while a switch handshake is in progress. They take the new value only once the new clock leg has been enabled.
- R9: No high or low phase of cpu_clk is shorter than the shortest input half-period. No selector ever enables two legs at once.
- R10: A write to address 3 loads bits [7:0] into pll_mult only if the value lies between 128 and 250 inclusive. Any other value leaves pll_mult unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_clk | input | 1 | Clock of the control write port |
| cfg_we | input | 1 | Write strobe for one control word |
| cfg_addr | input | 2 | Word address: 0/1 channel, 2 top select, 3 multiplier |
| cfg_wdata | input | 32 | Write data |
| xtal_clk | input | 1 | Crystal reference clock |
| fdiv2_clk | input | 1 | Fixed clock divided by two |
| fdiv3_clk | input | 1 | Fixed clock divided by three |
| pll_clk | input | 1 | PLL output clock |
| cpu_clk | output | 1 | Glitch-free CPU clock |
| active_chan | output | 1 | Channel currently driving the dynamic path |
| active_pll | output | 1 | 1 when the PLL clock drives cpu_clk |
| pll_mult | output | 8 | Accepted PLL multiplier setting |

## Verification
The bench measures the cpu_clk period on every source and on a sweep of divide fields. It confirms the ratio moves only on a falling commit bit, so a design that latched the field on any write, or on the rising edge of the bit, would show the new period too early. It writes the parked channel while that channel is live, expecting no change, and a missing lock would move the clock under the core. It reads status right after a switch request, where a design that reported the request rather than the completed handshake would flip early. The multiplier limits are probed at 127, 128, 250 and 251. A pulse-width monitor runs throughout and catches any gating that cuts a phase short.

// File: rtl/cpuclk_pkg.sv
`timescale 1ns/1ps
package cpuclk_pkg;
    localparam int DIV_W  = 6;
    localparam int MULT_W = 8;

    localparam int SRC_LSB  = 0;
    localparam int POST_BIT = 4;
    localparam int DIV_LSB  = 8;
    localparam int EN_BIT   = 26;
    localparam int DYN_BIT  = 0;
    localparam int PLL_BIT  = 4;

    localparam logic [1:0] ADDR_CH0  = 2'd0;
    localparam logic [1:0] ADDR_CH1  = 2'd1;
    localparam logic [1:0] ADDR_TOP  = 2'd2;
    localparam logic [1:0] ADDR_MULT = 2'd3;

    typedef struct packed {
        logic [1:0][1:0]       src;
        logic [1:0]            post;
        logic [1:0]            en;
        logic [1:0][DIV_W-1:0] field;
        logic [1:0]            tgl;
        logic                  dyn_sel;
        logic                  pll_sel;
        logic [MULT_W-1:0]     mult;
    } cfg_t;
endpackage

// File: rtl/cpuclk_gf_mux.sv
`timescale 1ns/1ps
module cpuclk_gf_mux #(
    parameter int N         = 2,
    parameter int SYNC      = 2,
    parameter int RESET_LEG = 0,
    localparam int SW       = (N > 1) ? $clog2(N) : 1
) (
    input  logic          rst_n,
    input  logic [N-1:0]  clk_in,
    input  logic [SW-1:0] sel,
    output logic          clk_out,
    output logic [N-1:0]  leg_on
);
    logic [N-1:0] gated;

    for (genvar i = 0; i < N; i++) begin : g_leg
        logic [SYNC-1:0] sync_d, sync_q;
        logic            on_q;
        logic            others_on;

        assign others_on = |(leg_on & ~(N'(1) << i));

        always_comb begin
            sync_d = {sync_q[SYNC-2:0], (sel == SW'(i)) & ~others_on};
        end

        always_ff @(posedge clk_in[i] or negedge rst_n) begin
            if (!rst_n) sync_q <= {SYNC{i == RESET_LEG}};
            else        sync_q <= sync_d;
        end

        always_ff @(negedge clk_in[i] or negedge rst_n) begin
            if (!rst_n) on_q <= (i == RESET_LEG);
            else        on_q <= sync_q[SYNC-1];
        end

        assign leg_on[i] = on_q;
        assign gated[i]  = clk_in[i] & on_q;
    end

    assign clk_out = |gated;
endmodule

// File: rtl/cpuclk_divider.sv
`timescale 1ns/1ps
module cpuclk_divider #(
    parameter int DIV_W = 6,
    parameter int SYNC  = 2,
    localparam int CW   = DIV_W + 1
) (
    input  logic             rst_n,
    input  logic             clk_src,
    input  logic [DIV_W-1:0] div_field,
    input  logic             commit_tgl,
    output logic             clk_div
);
    typedef struct packed {
        logic [SYNC-1:0] tgl_sync;
        logic            tgl_seen;
        logic            load_pend;
        logic [CW-1:0]   cnt;
        logic [CW-1:0]   last;
        logic            out;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    pend;

    always_comb begin
        st_d          = st_q;
        st_d.tgl_sync = {st_q.tgl_sync[SYNC-2:0], commit_tgl};
        st_d.tgl_seen = st_q.tgl_sync[SYNC-1];
        pend          = st_q.load_pend | (st_q.tgl_sync[SYNC-1] ^ st_q.tgl_seen);
        if (st_q.cnt == st_q.last) begin
            st_d.cnt       = '0;
            st_d.load_pend = 1'b0;
            if (pend) st_d.last = CW'(div_field) + CW'(1);
        end else begin
            st_d.cnt       = st_q.cnt + CW'(1);
            st_d.load_pend = pend;
        end
        st_d.out = st_d.cnt < ((st_d.last + CW'(1)) >> 1);
    end

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cnt  <= CW'(1);
            st_q.last <= CW'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_div = st_q.out;
endmodule

// File: rtl/cpuclk_sel_status.sv
`timescale 1ns/1ps
module cpuclk_sel_status #(
    parameter int SYNC = 2
) (
    input  logic       cfg_clk,
    input  logic       rst_n,
    input  logic [1:0] leg_on,
    output logic       active
);
    logic [SYNC-1:0][1:0] sync_d, sync_q;
    logic                 act_d, act_q;

    always_comb begin
        sync_d[0] = leg_on;
        for (int k = 1; k < SYNC; k++) sync_d[k] = sync_q[k-1];
        if (sync_q[SYNC-1][1])      act_d = 1'b1;
        else if (sync_q[SYNC-1][0]) act_d = 1'b0;
        else                        act_d = act_q;
    end

    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {SYNC{2'b01}};
            act_q  <= 1'b0;
        end else begin
            sync_q <= sync_d;
            act_q  <= act_d;
        end
    end

    assign active = act_q;
endmodule

// File: rtl/cpuclk_channel.sv
`timescale 1ns/1ps
module cpuclk_channel #(
    parameter int DIV_W = 6,
    parameter int SYNC  = 2
) (
    input  logic             rst_n,
    input  logic             xtal_clk,
    input  logic             fdiv2_clk,
    input  logic             fdiv3_clk,
    input  logic [1:0]       src_sel,
    input  logic             post_div,
    input  logic [DIV_W-1:0] div_field,
    input  logic             commit_tgl,
    output logic             clk_out,
    output logic [2:0]       src_on,
    output logic [1:0]       post_on
);
    logic src_clk;
    logic div_clk;

    cpuclk_gf_mux #(.N(3), .SYNC(SYNC), .RESET_LEG(0)) u_src_mux (
        .rst_n  (rst_n),
        .clk_in ({fdiv3_clk, fdiv2_clk, xtal_clk}),
        .sel    (src_sel),
        .clk_out(src_clk),
        .leg_on (src_on)
    );

    cpuclk_divider #(.DIV_W(DIV_W), .SYNC(SYNC)) u_div (
        .rst_n     (rst_n),
        .clk_src   (src_clk),
        .div_field (div_field),
        .commit_tgl(commit_tgl),
        .clk_div   (div_clk)
    );

    cpuclk_gf_mux #(.N(2), .SYNC(SYNC), .RESET_LEG(0)) u_post_mux (
        .rst_n  (rst_n),
        .clk_in ({div_clk, src_clk}),
        .sel    (post_div),
        .clk_out(clk_out),
        .leg_on (post_on)
    );
endmodule

// File: rtl/cpuclk_switch.sv
`timescale 1ns/1ps
module cpuclk_switch
    import cpuclk_pkg::*;
#(
    parameter int SYNC     = 2,
    parameter int MULT_MIN = 128,
    parameter int MULT_MAX = 250
) (
    input  logic              rst_n,
    input  logic              cfg_clk,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              xtal_clk,
    input  logic              fdiv2_clk,
    input  logic              fdiv3_clk,
    input  logic              pll_clk,
    output logic              cpu_clk,
    output logic              active_chan,
    output logic              active_pll,
    output logic [MULT_W-1:0] pll_mult
);
    cfg_t cfg_d, cfg_q;

    logic                  act_chan;
    logic                  act_pll;
    logic [1:0]            ch_clk;
    logic [1:0][2:0]       ch_src_on;
    logic [1:0][1:0]       ch_post_on;
    logic [1:0]            dyn_on;
    logic [1:0]            fin_on;
    logic                  dyn_clk;

    logic                  wr_ch;
    logic                  park_lock;
    logic [1:0]            wr_src;
    logic [DIV_W-1:0]      wr_field;
    logic [MULT_W-1:0]     mult_req;
    logic                  mult_ok;

    assign wr_ch     = cfg_addr[0];
    assign park_lock = cfg_q.dyn_sel | act_chan;
    assign wr_src    = cfg_wdata[SRC_LSB +: 2];
    assign wr_field  = cfg_wdata[DIV_LSB +: DIV_W];
    assign mult_req  = cfg_wdata[MULT_W-1:0];
    assign mult_ok   = (int'(mult_req) >= MULT_MIN) && (int'(mult_req) <= MULT_MAX);

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            case (cfg_addr)
                ADDR_CH0, ADDR_CH1: begin
                    if (!(wr_ch && park_lock)) begin
                        cfg_d.src[wr_ch]  = (wr_src == 2'd3) ? 2'd0 : wr_src;
                        cfg_d.post[wr_ch] = cfg_wdata[POST_BIT];
                    end
                    cfg_d.en[wr_ch] = cfg_wdata[EN_BIT];
                    if (cfg_q.en[wr_ch] && !cfg_wdata[EN_BIT]) begin
                        cfg_d.field[wr_ch] = wr_field;
                        cfg_d.tgl[wr_ch]   = ~cfg_q.tgl[wr_ch];
                    end
                end
                ADDR_TOP: begin
                    cfg_d.dyn_sel = cfg_wdata[DYN_BIT];
                    cfg_d.pll_sel = cfg_wdata[PLL_BIT];
                end
                default: begin
                    if (mult_ok) cfg_d.mult = mult_req;
                end
            endcase
        end
    end

    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            cfg_q.mult <= MULT_W'(MULT_MIN);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    for (genvar c = 0; c < 2; c++) begin : g_chan
        cpuclk_channel #(.DIV_W(DIV_W), .SYNC(SYNC)) u_chan (
            .rst_n     (rst_n),
            .xtal_clk  (xtal_clk),
            .fdiv2_clk (fdiv2_clk),
            .fdiv3_clk (fdiv3_clk),
            .src_sel   (cfg_q.src[c]),
            .post_div  (cfg_q.post[c]),
            .div_field (cfg_q.field[c]),
            .commit_tgl(cfg_q.tgl[c]),
            .clk_out   (ch_clk[c]),
            .src_on    (ch_src_on[c]),
            .post_on   (ch_post_on[c])
        );
    end

    cpuclk_gf_mux #(.N(2), .SYNC(SYNC), .RESET_LEG(0)) u_dyn_mux (
        .rst_n  (rst_n),
        .clk_in (ch_clk),
        .sel    (cfg_q.dyn_sel),
        .clk_out(dyn_clk),
        .leg_on (dyn_on)
    );

    cpuclk_gf_mux #(.N(2), .SYNC(SYNC), .RESET_LEG(0)) u_fin_mux (
        .rst_n  (rst_n),
        .clk_in ({pll_clk, dyn_clk}),
        .sel    (cfg_q.pll_sel),
        .clk_out(cpu_clk),
        .leg_on (fin_on)
    );

    cpuclk_sel_status #(.SYNC(SYNC)) u_chan_status (
        .cfg_clk(cfg_clk),
        .rst_n  (rst_n),
        .leg_on (dyn_on),
        .active (act_chan)
    );

    cpuclk_sel_status #(.SYNC(SYNC)) u_pll_status (
        .cfg_clk(cfg_clk),
        .rst_n  (rst_n),
        .leg_on (fin_on),
        .active (act_pll)
    );

    assign active_chan = act_chan;
    assign active_pll  = act_pll;
    assign pll_mult    = cfg_q.mult;
endmodule

// File: rtl/cpuclk_switch_checker.sv
`timescale 1ns/1ps
module cpuclk_switch_checker
    import cpuclk_pkg::*;
#(
    parameter int MULT_MIN = 128,
    parameter int MULT_MAX = 250
) (
    input logic              cfg_clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [1:0]        cfg_addr,
    input logic              wr_en_bit,
    input logic [MULT_W-1:0] wr_low,
    input logic [MULT_W-1:0] pll_mult,
    input cfg_t              cfg_q,
    input logic [1:0][2:0]   ch_src_on,
    input logic [1:0][1:0]   ch_post_on,
    input logic [1:0]        dyn_on,
    input logic [1:0]        fin_on
);
    AST_SRC0_EXCL: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        $onehot0(ch_src_on[0])); // R9
    AST_SRC1_EXCL: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        $onehot0(ch_src_on[1])); // R9
    AST_POST0_EXCL: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        $onehot0(ch_post_on[0])); // R9
    AST_POST1_EXCL: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        $onehot0(ch_post_on[1])); // R9
    AST_DYN_EXCL: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        $onehot0(dyn_on)); // R9
    AST_FIN_EXCL: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        $onehot0(fin_on)); // R9
    AST_MULT_WINDOW: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (int'(pll_mult) >= MULT_MIN) && (int'(pll_mult) <= MULT_MAX)); // R10
    AST_MULT_REJECT: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        cfg_we && (cfg_addr == ADDR_MULT) &&
        ((int'(wr_low) < MULT_MIN) || (int'(wr_low) > MULT_MAX))
        |=> $stable(pll_mult)); // R10
    AST_DIV0_HOLD: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        cfg_we && (cfg_addr == ADDR_CH0) && !(cfg_q.en[0] && !wr_en_bit)
        |=> $stable(cfg_q.field[0]) && $stable(cfg_q.tgl[0])); // R5
    AST_DIV1_HOLD: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        cfg_we && (cfg_addr == ADDR_CH1) && !(cfg_q.en[1] && !wr_en_bit)
        |=> $stable(cfg_q.field[1]) && $stable(cfg_q.tgl[1])); // R5
    AST_PARK_LOCK: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        cfg_we && (cfg_addr == ADDR_CH1) && cfg_q.dyn_sel
        |=> $stable(cfg_q.src[1]) && $stable(cfg_q.post[1])); // R7
endmodule

bind cpuclk_switch cpuclk_switch_checker #(.MULT_MIN(MULT_MIN), .MULT_MAX(MULT_MAX)) u_chk (
    .cfg_clk   (cfg_clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .wr_en_bit (cfg_wdata[cpuclk_pkg::EN_BIT]),
    .wr_low    (cfg_wdata[cpuclk_pkg::MULT_W-1:0]),
    .pll_mult  (pll_mult),
    .cfg_q     (cfg_q),
    .ch_src_on (ch_src_on),
    .ch_post_on(ch_post_on),
    .dyn_on    (dyn_on),
    .fin_on    (fin_on)
);

// File: tb/test_cpuclk_switch.sv
`timescale 1ns/1ps
module test_cpuclk_switch;
    logic        rst_n = 1'b0;
    logic        cfg_clk = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        xtal_clk = 1'b0;
    logic        fdiv2_clk = 1'b0;
    logic        fdiv3_clk = 1'b0;
    logic        pll_clk = 1'b0;
    logic        cpu_clk;
    logic        active_chan;
    logic        active_pll;
    logic [7:0]  pll_mult;

    int  n_checks = 0;
    int  n_err = 0;
    bit  done = 0;
    bit  mon_en = 0;
    int  n_glitch = 0;
    real last_edge = 0.0;
    real min_width = 1.0e9;
    real prev_per = 42.0;
    real src_per[4];
    int  cur_field = 0;

    always #2  cfg_clk   = ~cfg_clk;
    always #21 xtal_clk  = ~xtal_clk;
    always #4  fdiv2_clk = ~fdiv2_clk;
    always #6  fdiv3_clk = ~fdiv3_clk;
    always #3  pll_clk   = ~pll_clk;

    cpuclk_switch i_cpuclk_switch (
        .rst_n      (rst_n),
        .cfg_clk    (cfg_clk),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .xtal_clk   (xtal_clk),
        .fdiv2_clk  (fdiv2_clk),
        .fdiv3_clk  (fdiv3_clk),
        .pll_clk    (pll_clk),
        .cpu_clk    (cpu_clk),
        .active_chan(active_chan),
        .active_pll (active_pll),
        .pll_mult   (pll_mult)
    );

    // R9 pulse-width monitor: shortest input half-period is 3 ns
    always @(cpu_clk) begin
        if (mon_en) begin
            if ($realtime - last_edge < min_width) min_width = $realtime - last_edge;
            if ($realtime - last_edge < 2.9) n_glitch++;
        end
        last_edge = $realtime;
    end

    function automatic real rabs(real v);
        return (v < 0.0) ? -v : v;
    endfunction

    function automatic logic [31:0] ch_word(int src, bit post, int field, bit en);
        logic [31:0] w;
        w        = 32'd0;
        w[1:0]   = src[1:0];
        w[4]     = post;
        w[13:8]  = field[5:0];
        w[26]    = en;
        return w;
    endfunction

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge cfg_clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge cfg_clk);
        cfg_we = 1'b0;
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_mult(string tag, logic [7:0] exp);
        @(negedge cfg_clk);
        n_checks++;
        if (pll_mult !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, pll_mult, exp);
        end
    endtask

    task automatic check_period(string tag, real exp);
        real t0, t1, t2;
        #(600.0 + 4.0 * (prev_per + exp));
        @(posedge cpu_clk); t0 = $realtime;
        @(posedge cpu_clk); t1 = $realtime;
        @(posedge cpu_clk); t2 = $realtime;
        prev_per = exp;
        n_checks++;
        if (rabs(t1 - t0 - exp) > 0.05 || rabs(t2 - t1 - exp) > 0.05) begin
            n_err++;
            $display("FAIL %s actual=%0.2f/%0.2f expected=%0.2f", tag, t1 - t0, t2 - t1, exp);
        end
    endtask

    initial begin
        src_per[0] = 42.0; src_per[1] = 8.0; src_per[2] = 12.0; src_per[3] = 42.0;
        #100;
        @(negedge cfg_clk);
        rst_n = 1'b1;
        #1 mon_en = 1;

        // R1 reset state
        check_bit("R1 active_chan", active_chan, 1'b0);
        check_bit("R1 active_pll", active_pll, 1'b0);
        check_mult("R1 pll_mult", 8'd128);
        check_period("R1 crystal period", 42.0);

        // R2 source sweep, raw output
        for (int s = 0; s < 4; s++) begin
            wr(2'd0, ch_word(s, 1'b0, cur_field, 1'b0));
            check_period($sformatf("R2 src=%0d", s), src_per[s]);
        end

        // R3 / R4 divided sweep using the commit protocol
        for (int s = 0; s < 3; s++) begin
            foreach (src_per[k]) begin
                int f;
                if (k == 3) continue;
                f = (k == 0) ? 0 : ((k == 1) ? 1 : 5);
                wr(2'd0, ch_word(s, 1'b1, cur_field, 1'b1));
                wr(2'd0, ch_word(s, 1'b1, f, 1'b0));
                cur_field = f;
                check_period($sformatf("R3 R4 src=%0d field=%0d", s, f), src_per[s] * real'(f + 2));
            end
        end

        // R5 writes without a falling commit bit (src 2, field 5 -> 84 ns)
        wr(2'd0, ch_word(2, 1'b1, 2, 1'b0));
        check_period("R5 field write, bit low", 84.0);
        wr(2'd0, ch_word(2, 1'b1, 2, 1'b1));
        check_period("R5 field write, bit rising", 84.0);
        wr(2'd0, ch_word(2, 1'b1, 2, 1'b0));
        check_period("R4 falling commit", 48.0);

        // R6 / R8 switch to parked channel 1 (third-rate raw)
        wr(2'd1, ch_word(2, 1'b0, 0, 1'b0));
        check_period("R6 channel 0 still drives", 48.0);
        wr(2'd2, 32'h0000_0001);
        check_bit("R8 status lags request", active_chan, 1'b0);
        check_period("R6 channel 1 period", 12.0);
        check_bit("R8 status after handshake", active_chan, 1'b1);

        // R7 parked channel locked while live
        wr(2'd1, ch_word(0, 1'b0, 0, 1'b0));
        check_period("R7 locked source write", 12.0);

        // R6 back to reprogrammed channel 0 (half-rate raw)
        wr(2'd0, ch_word(1, 1'b0, 2, 1'b0));
        check_period("R6 channel 0 idle reprogram", 12.0);
        wr(2'd2, 32'h0000_0000);
        check_period("R6 back to channel 0", 8.0);
        check_bit("R8 status back to 0", active_chan, 1'b0);

        // R7 write accepted once channel 1 is idle
        wr(2'd1, ch_word(0, 1'b0, 0, 1'b0));
        wr(2'd2, 32'h0000_0001);
        check_period("R7 idle write took effect", 42.0);

        // R6 PLL selection
        wr(2'd2, 32'h0000_0011);
        check_bit("R8 pll status lags", active_pll, 1'b0);
        check_period("R6 pll period", 6.0);
        check_bit("R6 active_pll", active_pll, 1'b1);
        check_bit("R6 active_chan kept", active_chan, 1'b1);
        wr(2'd2, 32'h0000_0001);
        check_period("R6 leave pll", 42.0);
        check_bit("R6 active_pll cleared", active_pll, 1'b0);

        // R10 multiplier window
        wr(2'd3, 32'd127); check_mult("R10 reject 127", 8'd128);
        wr(2'd3, 32'd250); check_mult("R10 accept 250", 8'd250);
        wr(2'd3, 32'd251); check_mult("R10 reject 251", 8'd250);
        wr(2'd3, 32'd128); check_mult("R10 accept 128", 8'd128);
        wr(2'd3, 32'd200); check_mult("R10 accept 200", 8'd200);
        wr(2'd3, 32'd0);   check_mult("R10 reject 0", 8'd200);

        // R9 glitch summary
        n_checks++;
        if (n_glitch != 0) begin
            n_err++;
            $display("FAIL R9 short phases actual=%0d (min %0.2f ns) expected=0", n_glitch, min_width);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end
endmodule